// File: doc/BRIEF.md
# I2C Register-File Target

This block is a target device on a two-wire serial bus. It holds a small bank of byte-wide registers and keeps an internal pointer into that bank. The controller addresses the block with a start condition and a 7-bit address plus a direction bit. In a write, the first byte after the address is a command byte that loads the pointer. Every later byte lands in the register the pointer selects, and the pointer then advances. After a repeated start with the direction bit set, the block returns register contents beginning at the pointer. The pointer keeps advancing across the burst and wraps at the end of the bank.

The clock and data lines are sampled with the system clock. Each line first passes through a two-flop synchroniser, and all edges, start conditions and stop conditions are detected on the synchronised copies. The block drives the data line only through an open-drain enable (`sdaOe` high pulls the line low). It does not stretch the clock, and it does not respond to general-call or 10-bit addresses. `NUM_REGS` must be a power of two.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset `sdaOe` is low, every register holds 0x00 and the pointer is 0.
- R2: A falling data line while the clock line is high is a start; a rising data line while the clock line is high is a stop, which returns the block to idle with `sdaOe` low.
- R3: Bits are taken on the rising clock edge, most significant first. The first byte after a start carries the address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). The block acknowledges only when bits 7..1 equal `DEV_ADDR`. After a mismatch it leaves the line released and changes no register until the next start or stop.
- R4: In a write, the byte after the address is acknowledged, and its low log2(`NUM_REGS`) bits load the pointer.
- R5: Every further written byte is acknowledged and stored at the pointer, and the pointer then increments, wrapping from `NUM_REGS`-1 to 0.
- R6: After an address byte with the direction bit set, the block sends the register at the pointer, most significant bit first, and increments the pointer (with wrap) after each byte sent. The pointer loaded in a write survives a repeated start.
- R7: During the ninth clock of a sent byte `sdaOe` is low. When the controller acknowledges (line low), the next byte follows. When it does not (line high), the block drives nothing more until a start or stop, and the pointer stays where the last byte sent left it.
- R8: `sdaOe` never changes while the clock line has been high for several system clocks; new data and acknowledge levels appear only after a falling clock edge.
- R9: A start or stop in the middle of a byte discards the partial byte. A start restarts address reception with a cleared bit count; neither changes a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired bus value) |
| sdaOe | output | 1 | Open-drain enable; high pulls the data line low |

## Verification
Two of the block's functions can land on the same system-clock cycle. The condition detector may flag a start or stop while the receiver is holding a partly shifted byte and a live bit count. Likewise, the pointer-advance logic may have to wrap from the last register while a command load or a read reload uses it. The bench cuts bytes after three or four bits with a start or a stop, and it writes and reads bursts that cross the last register. It then reads the bank back, so that a lost or misplaced byte, or a pointer that moved wrongly, shows up in the data returned at the port.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } tgtState_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_DATA
  } rxKind_e;

  // strobes from control to datapath, at most a few per cycle
  typedef struct packed {
    logic clrBits;
    logic ackOn;
    logic oeOff;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
    logic incPtr;
  } dpCtl_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  dpCtl_t     ctl,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startDet,
  output logic       stopDet,
  output logic       bitFull,
  output logic       bitCntNz,
  output logic       sdaSync,
  output logic [7:0] rxByte,
  output logic       sdaOe
);

  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_REGS - 1);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  if ((NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_depth
    $error("NUM_REGS must be a power of two");
  end

  // synchronisers: index 1 = clock line, index 0 = data line
  logic [1:0] rawIn;
  logic [1:0] syncOut;
  assign rawIn = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_tgt_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
    ) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (rawIn[g]),
      .dout(syncOut[g])
    );
  end

  logic sclS, sdaS, sclD, sdaD;
  assign sclS = syncOut[1];
  assign sdaS = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign sdaSync  = sdaS;

  // bit counter and receive shifter
  logic [3:0] bitCnt;
  logic [7:0] rxShift;

  assign bitFull  = (bitCnt == BITS_PER_BYTE);
  assign bitCntNz = (bitCnt != 4'd0);
  assign rxByte   = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else begin
      if (ctl.clrBits) bitCnt <= '0;
      else if (sclRise && !bitFull) bitCnt <= bitCnt + 4'd1;
      if (sclRise && !bitFull) rxShift <= {rxShift[6:0], sdaS};
    end
  end

  // pointer and register bank
  logic [PTR_W-1:0] ptrQ;
  logic [7:0]       regFile [NUM_REGS];
  logic [7:0]       txShift;
  logic             sdaOeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (ctl.loadPtr) begin
      ptrQ <= rxShift[PTR_W-1:0];
    end else if (ctl.incPtr || ctl.writeReg) begin
      ptrQ <= (ptrQ == LAST_PTR) ? '0 : ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (ctl.writeReg) begin
      regFile[ptrQ] <= rxShift;
    end
  end

  // transmit shifter and open-drain enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      sdaOeQ  <= 1'b0;
    end else begin
      if (ctl.loadTx)       txShift <= regFile[ptrQ];
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b0};

      if (ctl.oeOff)        sdaOeQ <= 1'b0;
      else if (ctl.ackOn)   sdaOeQ <= 1'b1;
      else if (ctl.loadTx)  sdaOeQ <= ~regFile[ptrQ][7];
      else if (ctl.shiftTx) sdaOeQ <= ~txShift[6];
    end
  end

  assign sdaOe = sdaOeQ;

  // R8
  oe_quiet_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclD && !startDet && !stopDet) |=> $stable(sdaOeQ));

  // R5
  write_full_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeReg |-> bitFull);

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       bitFull,
  input  logic       bitCntNz,
  input  logic       sdaSync,
  input  logic [7:0] rxByte,
  input  logic       sdaOe,
  output dpCtl_t     ctl
);

  tgtState_e stateQ, stateD;
  rxKind_e   kindQ, kindD;
  logic      rwQ, rwD;
  logic      mAckQ, mAckD;

  always_comb begin
    stateD = stateQ;
    kindD  = kindQ;
    rwD    = rwQ;
    mAckD  = mAckQ;
    ctl    = '0;
    if (stopDet) begin
      stateD    = ST_IDLE;
      ctl.oeOff = 1'b1;
    end else if (startDet) begin
      stateD      = ST_RX;
      kindD       = K_ADDR;
      ctl.clrBits = 1'b1;
      ctl.oeOff   = 1'b1;
    end else begin
      case (stateQ)
        ST_RX: begin
          if (sclFall && bitFull) begin
            case (kindQ)
              K_ADDR: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  rwD       = rxByte[0];
                  ctl.ackOn = 1'b1;
                  stateD    = ST_RX_ACK;
                end else begin
                  stateD = ST_SKIP;
                end
              end
              K_CMD: begin
                ctl.loadPtr = 1'b1;
                ctl.ackOn   = 1'b1;
                stateD      = ST_RX_ACK;
              end
              default: begin
                ctl.writeReg = 1'b1;
                ctl.ackOn    = 1'b1;
                stateD       = ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            ctl.clrBits = 1'b1;
            if (rwQ && kindQ == K_ADDR) begin
              ctl.loadTx = 1'b1;
              stateD     = ST_TX;
            end else begin
              ctl.oeOff = 1'b1;
              kindD     = (kindQ == K_ADDR) ? K_CMD : K_DATA;
              stateD    = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitFull) begin
              ctl.oeOff  = 1'b1;
              ctl.incPtr = 1'b1;
              stateD     = ST_TX_ACK;
            end else if (bitCntNz) begin
              ctl.shiftTx = 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) mAckD = ~sdaSync;
          if (sclFall) begin
            if (mAckQ) begin
              ctl.clrBits = 1'b1;
              ctl.loadTx  = 1'b1;
              stateD      = ST_TX;
            end else begin
              stateD = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      kindQ  <= K_ADDR;
      rwQ    <= 1'b0;
      mAckQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      kindQ  <= kindD;
      rwQ    <= rwD;
      mAckQ  <= mAckD;
    end
  end

  // R7
  tx_ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_TX_ACK) |-> !sdaOe);

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE || stateQ == ST_SKIP) |-> !sdaOe);

  // R4
  rx_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RX) |-> !sdaOe);

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (stateQ == ST_IDLE && !sdaOe));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  dpCtl_t     ctl;
  logic       sclRise, sclFall, startDet, stopDet;
  logic       bitFull, bitCntNz, sdaSync;
  logic [7:0] rxByte;

  i2c_tgt_dp #(
    .NUM_REGS   (NUM_REGS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .ctl     (ctl),
    .sclRise (sclRise),
    .sclFall (sclFall),
    .startDet(startDet),
    .stopDet (stopDet),
    .bitFull (bitFull),
    .bitCntNz(bitCntNz),
    .sdaSync (sdaSync),
    .rxByte  (rxByte),
    .sdaOe   (sdaOe)
  );

  i2c_tgt_ctrl #(
    .DEV_ADDR(DEV_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclRise (sclRise),
    .sclFall (sclFall),
    .startDet(startDet),
    .stopDet (stopDet),
    .bitFull (bitFull),
    .bitCntNz(bitCntNz),
    .sdaSync (sdaSync),
    .rxByte  (rxByte),
    .sdaOe   (sdaOe),
    .ctl     (ctl)
  );

endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;

  localparam logic [6:0] ADDR = 7'h2A;
  localparam int NREG = 8;
  localparam int H = 10;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic sdaBus;

  assign sdaBus = mSda & ~sdaOe;

  always #5 clk = ~clk;

  i2c_reg_target #(.DEV_ADDR(ADDR), .NUM_REGS(NREG)) u_dut (
    .clk  (clk),
    .rstN (rstN),
    .sclIn(mScl),
    .sdaIn(sdaBus),
    .sdaOe(sdaOe)
  );

  int total = 0;
  int bad = 0;
  int ptrM = 0;
  int viol = 0;
  int sclHighCnt = 0;
  logic prevOe = 1'b0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [8];

  // R8 monitor: enable must not move while the clock line sits high
  always @(posedge clk) begin
    if (rstN) begin
      if (sdaOe != prevOe && sclHighCnt >= 4) viol++;
      sclHighCnt = mScl ? sclHighCnt + 1 : 0;
    end
    prevOe = sdaOe;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic startC();
    tick(Q); mSda = 1'b1; tick(H); mScl = 1'b1; tick(H); mSda = 1'b0; tick(H); mScl = 1'b0;
  endtask

  task automatic stopC();
    tick(Q); mSda = 1'b0; tick(H); mScl = 1'b1; tick(H); mSda = 1'b1; tick(H);
  endtask

  task automatic wrBit(bit b);
    tick(Q); mSda = b; tick(H); mScl = 1'b1; tick(H); mScl = 1'b0;
  endtask

  task automatic rdBit(output bit b);
    tick(Q); mSda = 1'b1; tick(H); mScl = 1'b1; tick(H / 2);
    @(negedge clk) b = sdaBus;
    tick(H / 2); mScl = 1'b0;
  endtask

  task automatic wrByte(logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) wrBit(v[i]);
    rdBit(ack);
  endtask

  task automatic rdByte(bit doAck, output logic [7:0] v, output bit rel);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rdBit(b);
      v[i] = b;
    end
    tick(Q); mSda = doAck ? 1'b0 : 1'b1; tick(H); mScl = 1'b1; tick(H / 2);
    @(negedge clk) rel = !sdaOe;
    tick(H / 2); mScl = 1'b0;
  endtask

  // address byte, command, n data bytes from wbuf, stop
  task automatic writeTx(logic [6:0] a, logic [7:0] cmd, int n);
    bit ack;
    bit hit;
    hit = (a == ADDR);
    startC();
    wrByte({a, 1'b0}, ack);
    check("R3 address ack", ack, hit ? 0 : 1);
    wrByte(cmd, ack);
    check("R4 command ack", ack, hit ? 0 : 1);
    if (hit) ptrM = cmd % NREG;
    for (int i = 0; i < n; i++) begin
      wrByte(wbuf[i], ack);
      check("R5 data ack", ack, hit ? 0 : 1);
      if (hit) begin
        model[ptrM] = wbuf[i];
        ptrM = (ptrM + 1) % NREG;
      end
    end
    stopC();
  endtask

  task automatic readBurst(int n);
    logic [7:0] v;
    bit rel;
    for (int i = 0; i < n; i++) begin
      rdByte(i != n - 1, v, rel);
      check("R6 read data", v, model[ptrM]);
      check("R7 ninth clock released", rel, 1);
      ptrM = (ptrM + 1) % NREG;
    end
  endtask

  task automatic readCur(int n);
    bit ack;
    startC();
    wrByte({ADDR, 1'b1}, ack);
    check("R3 read address ack", ack, 0);
    readBurst(n);
    stopC();
  endtask

  task automatic readAt(logic [7:0] cmd, int n);
    bit ack;
    startC();
    wrByte({ADDR, 1'b0}, ack);
    check("R3 address ack", ack, 0);
    wrByte(cmd, ack);
    check("R4 command ack", ack, 0);
    ptrM = cmd % NREG;
    startC();
    wrByte({ADDR, 1'b1}, ack);
    check("R6 repeated start ack", ack, 0);
    readBurst(n);
    stopC();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    bit rel;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(5);
    @(negedge clk);
    check("R1 released after reset", sdaOe, 0);

    // R1: bank reads zero from pointer 0
    readCur(NREG);

    // R2: start recognised, stop releases
    startC();
    wrByte({ADDR, 1'b0}, ack);
    check("R2 start then address ack", ack, 0);
    stopC();
    @(negedge clk);
    check("R2 released after stop", sdaOe, 0);

    // R4 R5 R6: plain write then read back
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    writeTx(ADDR, 8'h02, 3);
    readAt(8'h02, 3);

    // R5: write across the last register; R6: read across it
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    writeTx(ADDR, 8'h07, 2);
    readAt(8'h06, 4);

    // R3: foreign address changes nothing
    wbuf[0] = 8'hFF; wbuf[1] = 8'hEE;
    writeTx(ADDR ^ 7'h01, 8'h01, 2);
    readAt(8'h00, NREG);

    // R7: after NAK nothing is driven, pointer unchanged
    ptrM = 1;
    readAt(8'h01, 1);
    startC();
    wrByte({ADDR, 1'b1}, ack);
    check("R7 read address ack", ack, 0);
    rdByte(1'b0, v, rel);
    check("R7 byte before NAK", v, model[ptrM]);
    ptrM = (ptrM + 1) % NREG;
    rdByte(1'b0, v, rel);
    check("R7 silent after NAK", v, 8'hFF);
    stopC();
    readCur(2);

    // R9: start mid-byte
    startC();
    wrByte({ADDR, 1'b0}, ack);
    wrByte(8'h03, ack);
    for (int i = 0; i < 4; i++) wrBit(1'b1);
    startC();
    wrByte({ADDR, 1'b0}, ack);
    check("R9 address after mid-byte start", ack, 0);
    wrByte(8'h04, ack);
    wrByte(8'h77, ack);
    check("R9 data after mid-byte start", ack, 0);
    stopC();
    model[4] = 8'h77;
    ptrM = 5;
    // R9: stop mid-byte
    startC();
    wrByte({ADDR, 1'b0}, ack);
    wrByte(8'h05, ack);
    for (int i = 0; i < 3; i++) wrBit(1'b0);
    stopC();
    ptrM = 5;
    readCur(1);
    readAt(8'h03, 3);

    // random mix against the model
    for (int t = 0; t < 24; t++) begin
      int op;
      int n;
      op = $urandom_range(0, 2);
      n = $urandom_range(1, 5);
      if (op == 0) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        writeTx(ADDR, 8'($urandom), n);
      end else if (op == 1) begin
        readAt(8'($urandom), n);
      end else begin
        readCur(n);
      end
    end

    check("R8 enable steady while clock high", viol, 0);
    summary();
    $finish;
  end

endmodule